// File: doc/BRIEF.md
# Clock Synthesizer Reload Sequencer

This block is the user-side controller that reloads the counter and loop settings of an on-chip clock synthesizer through its serial reconfiguration port. When a start request is accepted it captures a parallel configuration word and a flag that says whether any divider, output counter, charge-pump or loop-filter setting was changed. It then plays out the full handshake on the synthesizer side. It raises the scan enable and waits one lead cycle, then shifts the word out serially with the most significant bit first, and drops the enable right after the last bit. Next it strobes the update line for one cycle and waits for the done flag to rise and then fall. If the flag was set, it pulses the synthesizer reset.

The controller runs on the scan clock. A busy level and a one-cycle finished pulse tell the user logic when the sequence is over. A watchdog bounds the time spent waiting on the done flag. If done has not fallen within a set number of cycles after the update strobe, the sequence is abandoned and a fault level is raised. The sequence can be started again any number of times, back to back.

Top module: `clksynth_reload_ctrl`

## Requirements
- R1: After reset, scan_en_o, scan_data_o, update_o, synth_rst_o, busy_o, finished_o and fault_o are all 0.
- R2: A high start_i sampled while idle starts a sequence. scan_en_o then stays high for exactly WORD_W+1 consecutive cycles, and the first of those cycles is a lead cycle that carries no data.
- R3: In the WORD_W cycles that follow the lead cycle, scan_data_o presents the word captured at start, bit WORD_W-1 first and bit 0 last. Later changes on cfg_word_i and loop_changed_i have no effect.
- R4: update_o rises in the cycle right after scan_en_o falls, and scan_en_o is low while update_o is high.
- R5: update_o is high for exactly one cycle per sequence.
- R6: After the update strobe the block waits for done_i to go high and then low. It finishes no earlier than the cycle after it samples done_i low following a high.
- R7: If loop_changed_i was high at start, synth_rst_o is high for exactly RST_LEN cycles, starting the cycle after done_i is sampled low. Otherwise synth_rst_o stays low.
- R8: busy_o is high from the cycle after an accepted start through the cycle of the finished pulse. finished_o is high for exactly one cycle at the end, and busy_o is low in the cycle that follows.
- R9: A start_i pulse that arrives while busy_o is high is ignored, and the word being shifted is not disturbed.
- R10: If done_i has not fallen within WDOG_CYCLES cycles of waiting after the update strobe, the block sets fault_o, skips the synthesizer reset and issues finished_o WDOG_CYCLES+1 cycles after the update cycle. fault_o holds until the next accepted start clears it.
- R11: A new sequence can be started in the first idle cycle after a finished pulse, and it behaves exactly like the first one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock; all logic uses its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, sampled while idle |
| cfg_word_i | input | WORD_W | Configuration word to be shifted out |
| loop_changed_i | input | 1 | High when a divider, counter or loop setting changed |
| done_i | input | 1 | Done flag from the synthesizer |
| scan_en_o | output | 1 | Scan enable to the synthesizer |
| scan_data_o | output | 1 | Serial configuration data, MSB first |
| update_o | output | 1 | One-cycle update strobe |
| synth_rst_o | output | 1 | Synthesizer reset pulse |
| busy_o | output | 1 | Sequence in progress |
| finished_o | output | 1 | One-cycle end-of-sequence pulse |
| fault_o | output | 1 | Done flag did not fall in time on the last run |

## Verification
The bench uses an 8-bit word and sweeps all 256 values, so every bit position is seen at both levels. A reversed bit order, a lost lead cycle or an off-by-one shift count all corrupt the recovered word. The done-flag delays and the reset flag are derived from the word itself. This varies the rise and fall timing of done and checks the exact finish cycle against the arithmetic sum of the delays, which separates a design that finishes on the rising edge from one that waits for the fall. Some runs inject a start mid-sequence and change the word inputs after start to show that both are latched. Timeout runs, one with done never rising and one with done stuck high, pin down the watchdog window, the skipped reset and the fault clearing on the following run.

// File: rtl/clkrl_pkg.sv
package clkrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_LEAD    = 3'd1,
        ST_SHIFT   = 3'd2,
        ST_UPDATE  = 3'd3,
        ST_WAIT_HI = 3'd4,
        ST_WAIT_LO = 3'd5,
        ST_RESET   = 3'd6,
        ST_FINISH  = 3'd7
    } seq_state_e;

endpackage

// File: rtl/clkrl_shifter.sv
// Parallel-in, serial-out register with a bit counter, MSB leaves first.
module clkrl_shifter #(
    parameter int WORD_W = 144
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              shift_i,
    output logic              bit_o,
    output logic              last_o
);
    localparam int CNT_W = (WORD_W > 2) ? $clog2(WORD_W) : 1;

    typedef struct packed {
        logic [WORD_W-1:0] sh;
        logic [CNT_W-1:0]  cnt;
    } shf_t;

    shf_t shf_d, shf_q;

    always_comb begin
        shf_d = shf_q;
        if (load_i) begin
            shf_d.sh  = word_i;
            shf_d.cnt = '0;
        end else if (shift_i) begin
            shf_d.sh  = {shf_q.sh[WORD_W-2:0], 1'b0};
            shf_d.cnt = shf_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shf_q <= '0;
        else        shf_q <= shf_d;
    end

    assign bit_o  = shf_q.sh[WORD_W-1];
    assign last_o = (shf_q.cnt == CNT_W'(WORD_W - 1));

endmodule

// File: rtl/clkrl_watchdog.sv
// Counts consecutive run cycles; flags the last permitted one.
module clkrl_watchdog #(
    parameter int LIMIT = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic expired_o
);
    localparam int WD_W = (LIMIT > 2) ? $clog2(LIMIT) : 1;

    typedef struct packed {
        logic [WD_W-1:0] cnt;
    } wd_t;

    wd_t wd_d, wd_q;
    logic at_end;

    assign at_end = (wd_q.cnt == WD_W'(LIMIT - 1));

    always_comb begin
        wd_d = wd_q;
        if (!run_i)       wd_d.cnt = '0;
        else if (!at_end) wd_d.cnt = wd_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wd_q <= '0;
        else        wd_q <= wd_d;
    end

    assign expired_o = run_i && at_end;

endmodule

// File: rtl/clksynth_reload_ctrl.sv
module clksynth_reload_ctrl
    import clkrl_pkg::*;
#(
    parameter int WORD_W      = 144,
    parameter int WDOG_CYCLES = 4096,
    parameter int RST_LEN     = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [WORD_W-1:0] cfg_word_i,
    input  logic              loop_changed_i,
    input  logic              done_i,
    output logic              scan_en_o,
    output logic              scan_data_o,
    output logic              update_o,
    output logic              synth_rst_o,
    output logic              busy_o,
    output logic              finished_o,
    output logic              fault_o
);
    localparam int RC_W = (RST_LEN > 2) ? $clog2(RST_LEN) : 1;

    typedef struct packed {
        seq_state_e      st;
        logic            chg;
        logic            fault;
        logic [RC_W-1:0] rcnt;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic load, shift, last_bit, ser_bit, wd_run, wd_expired;

    clkrl_shifter #(.WORD_W(WORD_W)) shifter_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .word_i  (cfg_word_i),
        .shift_i (shift),
        .bit_o   (ser_bit),
        .last_o  (last_bit)
    );

    assign wd_run = (ctl_q.st == ST_WAIT_HI) || (ctl_q.st == ST_WAIT_LO);

    clkrl_watchdog #(.LIMIT(WDOG_CYCLES)) wdog_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (wd_run),
        .expired_o (wd_expired)
    );

    always_comb begin
        ctl_d = ctl_q;
        load  = 1'b0;
        shift = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    ctl_d.st    = ST_LEAD;
                    ctl_d.chg   = loop_changed_i;
                    ctl_d.fault = 1'b0;
                    load        = 1'b1;
                end
            end
            ST_LEAD:   ctl_d.st = ST_SHIFT;
            ST_SHIFT: begin
                shift = 1'b1;
                if (last_bit) ctl_d.st = ST_UPDATE;
            end
            ST_UPDATE: ctl_d.st = ST_WAIT_HI;
            ST_WAIT_HI: begin
                if (done_i) begin
                    ctl_d.st = ST_WAIT_LO;
                end else if (wd_expired) begin
                    ctl_d.st    = ST_FINISH;
                    ctl_d.fault = 1'b1;
                end
            end
            ST_WAIT_LO: begin
                if (!done_i) begin
                    ctl_d.st   = ctl_q.chg ? ST_RESET : ST_FINISH;
                    ctl_d.rcnt = '0;
                end else if (wd_expired) begin
                    ctl_d.st    = ST_FINISH;
                    ctl_d.fault = 1'b1;
                end
            end
            ST_RESET: begin
                if (ctl_q.rcnt == RC_W'(RST_LEN - 1)) ctl_d.st = ST_FINISH;
                else                                  ctl_d.rcnt = ctl_q.rcnt + 1'b1;
            end
            ST_FINISH: ctl_d.st = ST_IDLE;
            default:   ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.st    <= ST_IDLE;
            ctl_q.chg   <= 1'b0;
            ctl_q.fault <= 1'b0;
            ctl_q.rcnt  <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign scan_en_o   = (ctl_q.st == ST_LEAD) || (ctl_q.st == ST_SHIFT);
    assign scan_data_o = (ctl_q.st == ST_SHIFT) && ser_bit;
    assign update_o    = (ctl_q.st == ST_UPDATE);
    assign synth_rst_o = (ctl_q.st == ST_RESET);
    assign busy_o      = (ctl_q.st != ST_IDLE);
    assign finished_o  = (ctl_q.st == ST_FINISH);
    assign fault_o     = ctl_q.fault;

endmodule

module clksynth_reload_ctrl_sva (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic done_i,
    input logic scan_en_o,
    input logic update_o,
    input logic synth_rst_o,
    input logic busy_o,
    input logic finished_o,
    input logic fault_o
);
    p_update_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        update_o |=> !update_o);

    p_update_no_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        update_o |-> !scan_en_o);

    p_enable_fall_update_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scan_en_o) |-> update_o);

    p_finish_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        finished_o |=> !finished_o);

    p_busy_ends_after_finish_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(finished_o));

    p_busy_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !finished_o && start_i) |=> busy_o);

    p_reset_quiet_bus_r7: assert property (@(posedge clk) disable iff (!rst_n)
        synth_rst_o |-> (!scan_en_o && !update_o && busy_o));

    p_reset_no_fault_r10: assert property (@(posedge clk) disable iff (!rst_n)
        synth_rst_o |-> !fault_o);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!scan_en_o && !update_o && !synth_rst_o && !finished_o));

    p_enable_starts_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scan_en_o) |-> $past(start_i));

    p_finish_done_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (finished_o && !fault_o) |-> !done_i);
endmodule

bind clksynth_reload_ctrl clksynth_reload_ctrl_sva sva_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .done_i      (done_i),
    .scan_en_o   (scan_en_o),
    .update_o    (update_o),
    .synth_rst_o (synth_rst_o),
    .busy_o      (busy_o),
    .finished_o  (finished_o),
    .fault_o     (fault_o)
);

// File: tb/clksynth_reload_ctrl_tb_top.sv
module clksynth_reload_ctrl_tb_top;
    localparam int W     = 8;
    localparam int LIMIT = 24;
    localparam int RLEN  = 3;
    localparam int NEVER = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [W-1:0] cfg_word = '0;
    logic loop_chg = 1'b0;
    logic done = 1'b0;
    logic scan_en_o, scan_data_o, update_o, synth_rst_o, busy_o, finished_o, fault_o;

    int vectors = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    clksynth_reload_ctrl #(.WORD_W(W), .WDOG_CYCLES(LIMIT), .RST_LEN(RLEN)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start),
        .cfg_word_i     (cfg_word),
        .loop_changed_i (loop_chg),
        .done_i         (done),
        .scan_en_o      (scan_en_o),
        .scan_data_o    (scan_data_o),
        .update_o       (update_o),
        .synth_rst_o    (synth_rst_o),
        .busy_o         (busy_o),
        .finished_o     (finished_o),
        .fault_o        (fault_o)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic run_seq(input logic [W-1:0] w, input logic chg, input int rise,
                           input int hold, input bit tmo, input bit poke);
        logic [W-1:0] cap = '0;
        int en_cyc = 0, upd = 0, upd_bad = 0, rstc = 0, rst_early = 0;
        int fin = 0, fin_early = 0, fin_k = -1, k = -1, cyc = 0;
        bit fell = 0, was_hi = 0, prev_en = 0, busy_bad = 0, fault_stale = 0;
        int exp_k;
        @(negedge clk);
        cfg_word = w;
        loop_chg = chg;
        start    = 1'b1;
        @(negedge clk);
        start    = 1'b0;
        cfg_word = ~w;
        loop_chg = ~chg;
        while (fin == 0 && cyc < 400) begin
            if (!busy_o) busy_bad = 1;
            if (cyc == 0 && fault_o) fault_stale = 1;
            if (scan_en_o) begin
                en_cyc++;
                if (en_cyc >= 2) cap = {cap[W-2:0], scan_data_o};
            end
            if (update_o) begin
                upd++;
                if (scan_en_o || !prev_en) upd_bad++;
                k = 0;
            end
            prev_en = scan_en_o;
            if (synth_rst_o) begin
                rstc++;
                if (!fell) rst_early++;
            end
            if (finished_o) begin
                fin++;
                fin_k = k;
                if (!fell && !tmo) fin_early++;
            end
            start = poke && (cyc == 3 || cyc == W + 2);
            if (k >= 0) begin
                done = (k >= rise) && (k < rise + hold);
                if (done) was_hi = 1;
                else if (was_hi) fell = 1;
                k++;
            end
            cyc++;
            @(negedge clk);
        end
        start = 1'b0;
        done  = 1'b0;
        exp_k = tmo ? LIMIT + 1 : (rise + hold + 1 + (chg ? RLEN : 0));
        chk(en_cyc == W + 1, "R2 enable cycle count", en_cyc, W + 1);
        chk(cap == w, poke ? "R9 word after busy start" : "R3 serial word", cap, w);
        chk(upd_bad == 0, "R4 update placement", upd_bad, 0);
        chk(upd == 1, "R5 update pulse count", upd, 1);
        chk(fin_early == 0, "R6 finish before done fall", fin_early, 0);
        chk(fin_k == exp_k, tmo ? "R10 timeout finish cycle" : "R6 finish cycle", fin_k, exp_k);
        chk(rstc == ((chg && !tmo) ? RLEN : 0), "R7 reset length", rstc, (chg && !tmo) ? RLEN : 0);
        chk(rst_early == 0, "R7 reset before done fall", rst_early, 0);
        chk(fin == 1 && busy_bad == 0, "R8 busy and finish", fin, 1);
        chk(!busy_o && !finished_o, "R8 idle after finish", busy_o, 0);
        chk(fault_stale == 0, "R10 fault cleared on start", fault_stale, 0);
        chk(fault_o == tmo, "R10 fault level", fault_o, tmo);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs after reset
        chk({scan_en_o, scan_data_o, update_o, synth_rst_o, busy_o, finished_o, fault_o} == 7'd0,
            "R1 reset state",
            {scan_en_o, scan_data_o, update_o, synth_rst_o, busy_o, finished_o, fault_o}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy_o && !scan_en_o, "R1 idle after release", busy_o, 0);
        // Exhaustive word sweep; R11 back-to-back runs
        for (int v = 0; v < (1 << W); v++) begin
            logic [W-1:0] wv = W'(v);
            run_seq(wv, wv[0] ^ wv[W-1], 1 + (v % 4), 1 + ((v >> 2) % 6), 1'b0, (v % 17) == 5);
        end
        // R10: done never rises, then done never falls
        run_seq(8'hA5, 1'b1, NEVER, 1, 1'b1, 1'b0);
        run_seq(8'h3C, 1'b1, 2, NEVER, 1'b1, 1'b0);
        // R10 fault clear and R11 restart after timeout
        run_seq(8'h81, 1'b1, 3, 4, 1'b0, 1'b0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule